// File: doc/BRIEF.md
# Special Bus Cycle Decoder

This block sits on the system side of a 64-bit processor bus. It watches every address strobe. A bus cycle counts as a special cycle only when its control qualifiers carry one fixed signature: control rather than data, I/O rather than memory, and write rather than read. For each special cycle, the block works out which event the processor is announcing. It does this from the active-low byte-enable pattern together with the two lowest address bits above the byte lane, A[4:3].

One clock after it samples such a cycle, the block answers with a single-cycle active-low ready pulse. In that same clock it raises exactly one strobe. The strobe is one of the six event strobes (stop grant, flush acknowledge, writeback, halt, flush, shutdown) or the unknown-encoding flag. The ready is returned even when the encoding cannot be decoded, so the processor never stalls waiting on the bus. Ordinary memory and I/O transfers pass through untouched: the block drives neither ready nor any strobe for them.

Top module: `spcyc_decoder`

## Requirements
- R1: A cycle is treated as special only when the strobe input is low and, in the same clock, D/C is 0, M/IO is 0 and W/R is 1. If any one of these qualifiers differs, no ready and no strobe are produced.
- R2: Byte enables FBh with A[4:3] = 10b and A[31:5] = 0 raise the stop-grant strobe.
- R3: Byte enables FBh with A[4:3] = 00b and A[31:5] = 0 raise the halt strobe.
- R4: With A[4:3] = 00b and A[31:5] = 0, byte enables EFh raise the flush-acknowledge strobe and F7h raise the writeback strobe.
- R5: With A[4:3] = 00b and A[31:5] = 0, byte enables FDh raise the flush strobe and FEh raise the shutdown strobe.
- R6: A special cycle with any nonzero bit in A[31:5] raises the unknown flag instead of an event strobe, and still gets ready.
- R7: A special cycle whose byte-enable and A[4:3] pair is not one of the six listed raises the unknown flag, and still gets ready.
- R8: Ready goes low in the clock that follows the sampled strobe. It stays low for exactly one clock unless another special cycle is sampled at once.
- R9: Every strobe is a one-clock pulse issued in the same clock as ready. Exactly one of the seven strobes is high whenever ready is low, and none is high otherwise.
- R10: While reset is asserted, ready is high and all strobes are low, whatever the bus inputs show.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe_n | input | 1 | Address strobe, active low |
| dc_sel | input | 1 | Data/control qualifier (0 = control) |
| mio_sel | input | 1 | Memory/IO qualifier (0 = I/O) |
| wr_sel | input | 1 | Write/read qualifier (1 = write) |
| lane_en_n | input | 8 | Active-low byte enables |
| addr_q | input | 29 | Address bits 31 down to 3 (bit 0 is A3) |
| ready_n | output | 1 | Single-cycle ready, active low |
| ev_stop_grant | output | 1 | Stop-grant event pulse |
| ev_flush_ack | output | 1 | Flush-acknowledge event pulse |
| ev_writeback | output | 1 | Writeback event pulse |
| ev_halt | output | 1 | Halt event pulse |
| ev_flush | output | 1 | Flush event pulse |
| ev_shutdown | output | 1 | Shutdown event pulse |
| ev_unknown | output | 1 | Unknown special-cycle encoding pulse |

## Verification
The bench builds the block with its default parameters: eight byte lanes and a 29-bit quadword address. With these values the whole A[31:5] field can be reached, so the bench can set single stray bits there as well as random patterns. Random byte enables cover both the six listed codes and unlisted ones. Because the qualifiers are also randomised independently, back-to-back special cycles occur, and so do near-miss signatures that differ from a special cycle in only one qualifier.

// File: rtl/spcyc_pkg.sv
package spcyc_pkg;

   localparam int NUM_EV = 6;

   typedef enum logic [2:0] {
      EV_STOP_GRANT = 3'd0,
      EV_FLUSH_ACK  = 3'd1,
      EV_WRITEBACK  = 3'd2,
      EV_HALT       = 3'd3,
      EV_FLUSH      = 3'd4,
      EV_SHUTDOWN   = 3'd5
   } ev_kind_e;

   // Active-low byte-enable pattern that identifies each event.
   function automatic logic [7:0] ev_lane_code(input int idx);
      case (idx)
         0:       return 8'hFB;
         1:       return 8'hEF;
         2:       return 8'hF7;
         3:       return 8'hFB;
         4:       return 8'hFD;
         default: return 8'hFE;
      endcase
   endfunction

   // Value of A[4:3] that goes with each event.
   function automatic logic [1:0] ev_sub_code(input int idx);
      return (idx == 0) ? 2'b10 : 2'b00;
   endfunction

endpackage

// File: rtl/spcyc_qualify.sv
module spcyc_qualify (
   input  logic strobe_n,
   input  logic dc_sel,
   input  logic mio_sel,
   input  logic wr_sel,
   output logic special
);
   // Fixed signature: control, I/O, write.
   always_comb begin
      special = ~strobe_n & ~dc_sel & ~mio_sel & wr_sel;
   end
endmodule

// File: rtl/spcyc_classify.sv
module spcyc_classify
   import spcyc_pkg::*;
#(
   parameter int BE_W   = 8,
   parameter int ADDR_W = 29
) (
   input  logic [BE_W-1:0]   lane_en_n,
   input  logic [ADDR_W-1:0] addr_q,
   output logic [NUM_EV-1:0] hit,
   output logic              unknown
);
   localparam int SUB_W = 2;
   localparam int UP_W  = ADDR_W - SUB_W;

   logic [SUB_W-1:0] sub;
   logic             upper_clear;

   always_comb begin
      sub         = addr_q[SUB_W-1:0];
      upper_clear = (addr_q[ADDR_W-1:SUB_W] == '0);
   end

   for (genvar i = 0; i < NUM_EV; i++) begin : g_match
      always_comb begin
         hit[i] = upper_clear
                & (lane_en_n == BE_W'(ev_lane_code(i)))
                & (sub == ev_sub_code(i));
      end
   end

   always_comb begin
      unknown = ~|hit;
   end

   if (UP_W < 1) begin : g_bad_addr
      $error("spcyc_classify: ADDR_W must exceed %0d", SUB_W);
   end
endmodule

// File: rtl/spcyc_respond.sv
module spcyc_respond
   import spcyc_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              special,
   input  logic [NUM_EV-1:0] hit,
   input  logic              unknown,
   output logic              ready_n,
   output logic [NUM_EV-1:0] ev_q,
   output logic              unk_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ready_n <= 1'b1;
         ev_q    <= '0;
         unk_q   <= 1'b0;
      end else if (special) begin
         ready_n <= 1'b0;
         ev_q    <= hit;
         unk_q   <= unknown;
      end else begin
         ready_n <= 1'b1;
         ev_q    <= '0;
         unk_q   <= 1'b0;
      end
   end
endmodule

// File: rtl/spcyc_decoder.sv
module spcyc_decoder
   import spcyc_pkg::*;
#(
   parameter int BE_W   = 8,
   parameter int ADDR_W = 29
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strobe_n,
   input  logic              dc_sel,
   input  logic              mio_sel,
   input  logic              wr_sel,
   input  logic [BE_W-1:0]   lane_en_n,
   input  logic [ADDR_W-1:0] addr_q,
   output logic              ready_n,
   output logic              ev_stop_grant,
   output logic              ev_flush_ack,
   output logic              ev_writeback,
   output logic              ev_halt,
   output logic              ev_flush,
   output logic              ev_shutdown,
   output logic              ev_unknown
);
   if (BE_W != 8) begin : g_bad_be
      $error("spcyc_decoder: BE_W must be 8 for a 64-bit bus");
   end

   logic              special;
   logic [NUM_EV-1:0] hit;
   logic              unknown;
   logic [NUM_EV-1:0] ev_q;

   spcyc_qualify u_qual (
      .strobe_n (strobe_n),
      .dc_sel   (dc_sel),
      .mio_sel  (mio_sel),
      .wr_sel   (wr_sel),
      .special  (special)
   );

   spcyc_classify #(.BE_W(BE_W), .ADDR_W(ADDR_W)) u_cls (
      .lane_en_n (lane_en_n),
      .addr_q    (addr_q),
      .hit       (hit),
      .unknown   (unknown)
   );

   spcyc_respond u_rsp (
      .clk     (clk),
      .rst_n   (rst_n),
      .special (special),
      .hit     (hit),
      .unknown (unknown),
      .ready_n (ready_n),
      .ev_q    (ev_q),
      .unk_q   (ev_unknown)
   );

   assign ev_stop_grant = ev_q[EV_STOP_GRANT];
   assign ev_flush_ack  = ev_q[EV_FLUSH_ACK];
   assign ev_writeback  = ev_q[EV_WRITEBACK];
   assign ev_halt       = ev_q[EV_HALT];
   assign ev_flush      = ev_q[EV_FLUSH];
   assign ev_shutdown   = ev_q[EV_SHUTDOWN];

   logic [NUM_EV:0] all_ev;
   assign all_ev = {ev_unknown, ev_q};

   // R1 / R8: a sampled special cycle earns ready in the next clock
   a_r8_ready_next: assert property (@(posedge clk) disable iff (!rst_n)
      (!strobe_n && !dc_sel && !mio_sel && wr_sel) |=> !ready_n);

   // R1: near-miss cycles earn no ready
   a_r1_no_ready: assert property (@(posedge clk) disable iff (!rst_n)
      !(!strobe_n && !dc_sel && !mio_sel && wr_sel) |=> ready_n);

   // R9: exactly one strobe accompanies ready
   a_r9_one_with_ready: assert property (@(posedge clk) disable iff (!rst_n)
      !ready_n |-> ($countones(all_ev) == 1));

   // R9: no strobe without ready
   a_r9_none_idle: assert property (@(posedge clk) disable iff (!rst_n)
      ready_n |-> (all_ev == '0));

   // R6: nonzero upper address bits yield the unknown flag
   a_r6_upper_unknown: assert property (@(posedge clk) disable iff (!rst_n)
      (!strobe_n && !dc_sel && !mio_sel && wr_sel && (addr_q[ADDR_W-1:2] != '0))
      |=> ev_unknown);

   // R3: halt encoding yields the halt strobe
   a_r3_halt: assert property (@(posedge clk) disable iff (!rst_n)
      (!strobe_n && !dc_sel && !mio_sel && wr_sel && lane_en_n == 8'hFB
       && addr_q == ADDR_W'(0)) |=> ev_halt);
endmodule

// File: tb/spcyc_decoder_tb_top.sv
module spcyc_decoder_tb_top;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        strobe_n, dc_sel, mio_sel, wr_sel;
   logic [7:0]  lane_en_n;
   logic [28:0] addr_q;
   logic        ready_n;
   logic        ev_stop_grant, ev_flush_ack, ev_writeback, ev_halt;
   logic        ev_flush, ev_shutdown, ev_unknown;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #10 clk = ~clk;

   spcyc_decoder dut_i (
      .clk(clk), .rst_n(rst_n), .strobe_n(strobe_n), .dc_sel(dc_sel),
      .mio_sel(mio_sel), .wr_sel(wr_sel), .lane_en_n(lane_en_n),
      .addr_q(addr_q), .ready_n(ready_n), .ev_stop_grant(ev_stop_grant),
      .ev_flush_ack(ev_flush_ack), .ev_writeback(ev_writeback),
      .ev_halt(ev_halt), .ev_flush(ev_flush), .ev_shutdown(ev_shutdown),
      .ev_unknown(ev_unknown)
   );

   // -1 none, 0 stop grant, 1 flush ack, 2 writeback, 3 halt,
   // 4 flush, 5 shutdown, 6 unknown
   function automatic int ref_kind(input logic s, d, m, w,
                                   input logic [7:0] b, input logic [28:0] a);
      if (!(s == 1'b0 && d == 1'b0 && m == 1'b0 && w == 1'b1)) return -1;
      if (a[28:2] != 0) return 6;
      if (b == 8'hFB && a[1:0] == 2'b10) return 0;
      if (a[1:0] != 2'b00) return 6;
      case (b)
         8'hEF: return 1;
         8'hF7: return 2;
         8'hFB: return 3;
         8'hFD: return 4;
         8'hFE: return 5;
         default: return 6;
      endcase
   endfunction

   function automatic string kind_tag(input int k);
      case (k)
         -1: return "R1";
         0: return "R2";
         1, 2: return "R4";
         3: return "R3";
         4, 5: return "R5";
         default: return "R7";
      endcase
   endfunction

   logic [6:0] exp_vec = '0;
   logic       exp_rdy = 1'b1;
   string      exp_tag = "R8";

   function automatic logic [6:0] act_vec();
      return {ev_unknown, ev_shutdown, ev_flush, ev_halt,
              ev_writeback, ev_flush_ack, ev_stop_grant};
   endfunction

   task automatic compare();
      checks++;
      if (ready_n !== exp_rdy || act_vec() !== exp_vec) begin
         errors++;
         $display("FAIL %s: ready_n=%b strobes=%b expected ready_n=%b strobes=%b",
                  exp_tag, ready_n, act_vec(), exp_rdy, exp_vec);
      end
   endtask

   // Check the previous cycle's result, then drive the next one.
   task automatic step(input logic s, d, m, w, input logic [7:0] b,
                       input logic [28:0] a, input string tag);
      int k;
      @(negedge clk);
      compare();
      strobe_n = s; dc_sel = d; mio_sel = m; wr_sel = w;
      lane_en_n = b; addr_q = a;
      k = ref_kind(s, d, m, w, b, a);
      exp_rdy = (k < 0);
      exp_vec = (k < 0) ? 7'd0 : (7'd1 << k);
      exp_tag = (tag == "") ? kind_tag(k) : tag;
   endtask

   task automatic idle(input string tag);
      step(1'b1, 1'b0, 1'b0, 1'b1, 8'hFF, 29'd0, tag);
   endtask

   initial begin
      void'($urandom(32'h5EC1A1));
      rst_n = 1'b0;
      // special halt cycle held during reset: must stay quiet (R10)
      strobe_n = 1'b0; dc_sel = 1'b0; mio_sel = 1'b0; wr_sel = 1'b1;
      lane_en_n = 8'hFB; addr_q = 29'd0;
      repeat (3) @(negedge clk);
      checks++;
      if (ready_n !== 1'b1 || act_vec() !== 7'd0) begin
         errors++;
         $display("FAIL R10: ready_n=%b strobes=%b expected ready_n=1 strobes=0000000",
                  ready_n, act_vec());
      end
      strobe_n = 1'b1;
      rst_n = 1'b1;
      idle("R10");

      // directed: every listed encoding
      step(0,0,0,1, 8'hFB, 29'b10, "R2");
      step(0,0,0,1, 8'hFB, 29'b00, "R3");
      step(0,0,0,1, 8'hEF, 29'b00, "R4");
      step(0,0,0,1, 8'hF7, 29'b00, "R4");
      step(0,0,0,1, 8'hFD, 29'b00, "R5");
      step(0,0,0,1, 8'hFE, 29'b00, "R5");
      // single cycle then idle: one-clock width (R8, R9)
      idle("R9");
      idle("R8");
      // near misses on each qualifier (R1)
      step(0,1,0,1, 8'hFB, 29'b00, "R1");
      step(0,0,1,1, 8'hFB, 29'b00, "R1");
      step(0,0,0,0, 8'hFB, 29'b00, "R1");
      step(1,0,0,1, 8'hFB, 29'b00, "R1");
      // stray upper address bits (R6)
      step(0,0,0,1, 8'hFB, 29'h4, "R6");
      step(0,0,0,1, 8'hFE, 29'h1000_0000, "R6");
      // unlisted codes (R7)
      step(0,0,0,1, 8'hFB, 29'b01, "R7");
      step(0,0,0,1, 8'hEF, 29'b10, "R7");
      step(0,0,0,1, 8'h00, 29'b00, "R7");
      idle("R8");

      // constrained random
      for (int n = 0; n < 3000; n++) begin
         logic [7:0]  b;
         logic [28:0] a;
         logic s, d, m, w;
         int pick;
         pick = int'($urandom % 8);
         case (pick)
            0: b = 8'hFB; 1: b = 8'hEF; 2: b = 8'hF7;
            3: b = 8'hFD; 4: b = 8'hFE;
            default: b = 8'($urandom);
         endcase
         a = ($urandom % 5 == 0) ? 29'($urandom) : {27'd0, 2'($urandom)};
         if ($urandom % 3 != 0) begin
            s = 0; d = 0; m = 0; w = 1;
         end else begin
            s = 1'($urandom); d = 1'($urandom); m = 1'($urandom); w = 1'($urandom);
         end
         if (s == 0 && d == 0 && m == 0 && w == 1 && a[28:2] != 0)
            step(s, d, m, w, b, a, "R6");
         else
            step(s, d, m, w, b, a, "");
      end
      idle("R8");
      idle("R8");
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule